// File: doc/BRIEF.md
# Macro Instruction Sequencer

This block steps through a short macro program held in an external instruction memory, one 32-bit word per clock cycle. It keeps a byte-addressed program counter, eight 32-bit general registers and an optional pending branch target. Branches are resolved inside the sequencer. Every other instruction is handed off, together with its two source operand values, to a downstream execute and dispatch stage. That stage returns register writes through a write-back port.

Branches and exits both have a delay slot. A taken branch normally runs the instruction that follows it and only then moves to the target. When the annul bit is set, the branch jumps straight to the target. An exit lets exactly one more instruction run and then stops. A pulse on `start` launches a run and carries the first argument, which appears in register 1. `done` marks normal completion. `error` reports any of these faults: a branch in a delay slot, an unknown opcode, or a fetch past the end of the program.

Top module: `macro_seq`

## Requirements
- R1: The program counter is a byte address that starts at 0 and moves up by 4 per instruction. `imem_addr` always carries the PC divided by 4.
- R2: A `start` pulse while idle clears every register and the PC and loads `start_arg` into register 1. A register that the new run has not yet written reads as zero, even if an earlier run wrote it.
- R3: Register 0 always reads as zero, and write-backs to it are dropped.
- R4: Instruction fields are: opcode [3:0], exit flag [4], annul flag [5], condition [6], destination register [9:7], source A [12:10], source B [15:13] and a signed 16-bit immediate [31:16]. A taken branch targets its own address plus the immediate times 4, and the offset may be negative.
- R5: A taken branch whose annul flag is 0 runs the next sequential word (the delay slot) and then continues at the target.
- R6: A taken branch whose annul flag is 1 goes directly to the target and skips the delay slot.
- R7: Opcode 7 is a branch. When its condition bit is 0 it is taken if source A equals zero. When its condition bit is 1 it is taken if source A is non-zero. A branch that is not taken falls through sequentially. A register written by the instruction just before the branch is already visible to the branch.
- R8: An instruction with the exit flag set runs one further instruction and then ends the run. When the exit sits in a branch delay slot, that further instruction is the one at the branch target.
- R9: A branch placed in any delay slot (of a branch or of an exit) raises `error` and ends the run.
- R10: Opcodes 8 to 15, and any fetch at a PC of PROG_WORDS×4 or above, raise `error` and return the block to idle. `error` stays high until the next start.
- R11: After reset, and between runs, `done`, `error` and `issue_valid` are low. `done` goes high for exactly one cycle, in the cycle after the last instruction of the run issues, and the block is idle afterwards.
- R12: Opcodes 0 to 6 are issued in the cycle they are fetched: `issue_valid` goes high, `issue_word` carries the instruction, and `issue_opa`/`issue_opb` carry the values of source A and source B. Branches are never issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launches a run when idle |
| start_arg | input | 32 | First argument, loaded into register 1 |
| imem_addr | output | AW | Instruction word index (PC/4) |
| imem_rdata | input | 32 | Instruction word at imem_addr, same cycle |
| issue_valid | output | 1 | A non-branch instruction is handed off |
| issue_word | output | 32 | Instruction being handed off |
| issue_opa | output | 32 | Value of source A register |
| issue_opb | output | 32 | Value of source B register |
| wb_en | input | 1 | Register write-back enable |
| wb_idx | input | 3 | Write-back register index |
| wb_data | input | 32 | Write-back value |
| done | output | 1 | One-cycle pulse at the end of a normal run |
| error | output | 1 | Fault flag, held until the next start |

## Verification
The main sweep uses one fixed program and varies three things: the annul flag, the condition bit, and whether the tested register is zero. From the sequence of issued instructions it separates the not-taken, taken-with-slot and annulled outcomes. Separate programs cover the remaining control-flow cases:
- a backward annulled jump;
- an exit inside a branch delay slot, which must retire the target rather than the next word;
- a branch that reads a register written by the instruction just before it.

Fault programs place a branch in a branch slot, a branch in an exit slot, an unknown opcode, a jump past the program end and a run off the last word. Each must stop with `error` after exactly the expected issued instructions. Operand checks show that register 0 and registers from an earlier run read as zero, and that register 1 holds the start argument.

// File: rtl/mseq_pkg.sv
package mseq_pkg;
    localparam int RIDX_W = 3;
    localparam int NREG   = 1 << RIDX_W;
    localparam int WORD_W = 32;

    localparam logic [3:0] OP_BRANCH   = 4'd7;
    localparam logic [3:0] OP_LAST_FWD = 4'd6;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic [15:0]       imm;
        logic [RIDX_W-1:0] src_b;
        logic [RIDX_W-1:0] src_a;
        logic [RIDX_W-1:0] dst;
        logic              on_nz;
        logic              annul;
        logic              exit_f;
        logic [3:0]        op;
    } instr_t;
endpackage

// File: rtl/mseq_decode.sv
module mseq_decode
    import mseq_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output instr_t            ins,
    output logic              is_branch,
    output logic              legal,
    output logic [WORD_W-1:0] br_off
);
    always_comb begin
        ins       = instr_t'(word);
        is_branch = (ins.op == OP_BRANCH);
        legal     = is_branch || (ins.op <= OP_LAST_FWD);
        br_off    = {{(WORD_W-18){ins.imm[15]}}, ins.imm, 2'b00};
    end
endmodule

// File: rtl/mseq_regfile.sv
module mseq_regfile
    import mseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic [WORD_W-1:0] clr_r1,
    input  logic              we,
    input  logic [RIDX_W-1:0] waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [RIDX_W-1:0] ra_a,
    input  logic [RIDX_W-1:0] ra_b,
    output logic [WORD_W-1:0] rd_a,
    output logic [WORD_W-1:0] rd_b
);
    logic [WORD_W-1:0] rf_q [NREG];
    logic [WORD_W-1:0] rf_d [NREG];

    always_comb begin
        for (int i = 0; i < NREG; i++) rf_d[i] = rf_q[i];
        if (clr) begin
            for (int i = 0; i < NREG; i++) rf_d[i] = '0;
            rf_d[1] = clr_r1;
        end else if (we && (waddr != '0)) begin
            rf_d[waddr] = wdata;
        end
        rf_d[0] = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) rf_q[i] <= '0;
        end else begin
            for (int i = 0; i < NREG; i++) rf_q[i] <= rf_d[i];
        end
    end

    assign rd_a = (ra_a == '0) ? '0 : rf_q[ra_a];
    assign rd_b = (ra_b == '0) ? '0 : rf_q[ra_b];

    AST_START_LOADS_R1: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (rf_q[1] == $past(clr_r1))) else $error("r1 load"); // R2
    AST_R0_DROPS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (we && waddr == '0) |=> (rd_a == '0 || ra_a != '0)) else $error("r0 write"); // R3
endmodule

// File: rtl/macro_seq.sv
module macro_seq
    import mseq_pkg::*;
#(
    parameter int PROG_WORDS = 64,
    localparam int AW        = $clog2(PROG_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [31:0]       start_arg,
    output logic [AW-1:0]     imem_addr,
    input  logic [31:0]       imem_rdata,
    output logic              issue_valid,
    output logic [31:0]       issue_word,
    output logic [31:0]       issue_opa,
    output logic [31:0]       issue_opb,
    input  logic              wb_en,
    input  logic [2:0]        wb_idx,
    input  logic [31:0]       wb_data,
    output logic              done,
    output logic              error
);
    localparam logic [WORD_W-1:0] PROG_BYTES = WORD_W'(PROG_WORDS * 4);

    typedef struct packed {
        seq_state_e        st;
        logic [WORD_W-1:0] pc;
        logic              pend_v;
        logic [WORD_W-1:0] pend_pc;
        logic              in_slot;
        logic              exit_pend;
        logic              err;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    instr_t            ins;
    logic              is_branch, legal, fetch_ok, taken, fault, rf_clr;
    logic [WORD_W-1:0] br_off, seq_pc, opa, opb;

    mseq_decode u_dec (
        .word      (imem_rdata),
        .ins       (ins),
        .is_branch (is_branch),
        .legal     (legal),
        .br_off    (br_off)
    );

    mseq_regfile u_rf (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (rf_clr),
        .clr_r1 (start_arg),
        .we     (wb_en),
        .waddr  (wb_idx),
        .wdata  (wb_data),
        .ra_a   (ins.src_a),
        .ra_b   (ins.src_b),
        .rd_a   (opa),
        .rd_b   (opb)
    );

    assign imem_addr = ctl_q.pc[AW+1:2];
    assign fetch_ok  = (ctl_q.pc < PROG_BYTES);
    assign taken     = ins.on_nz ? (opa != '0) : (opa == '0);
    assign seq_pc    = ctl_q.pend_v ? ctl_q.pend_pc : (ctl_q.pc + 32'd4);
    assign fault     = !fetch_ok || !legal || (is_branch && ctl_q.in_slot);

    always_comb begin
        ctl_d       = ctl_q;
        issue_valid = 1'b0;
        rf_clr      = 1'b0;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (start) begin
                    ctl_d.st        = ST_RUN;
                    ctl_d.pc        = '0;
                    ctl_d.pend_v    = 1'b0;
                    ctl_d.pend_pc   = '0;
                    ctl_d.in_slot   = 1'b0;
                    ctl_d.exit_pend = 1'b0;
                    ctl_d.err       = 1'b0;
                    rf_clr          = 1'b1;
                end
            end
            ST_RUN: begin
                if (fault) begin
                    ctl_d.err = 1'b1;
                    ctl_d.st  = ST_IDLE;
                end else begin
                    ctl_d.pc      = seq_pc;
                    ctl_d.pend_v  = 1'b0;
                    ctl_d.in_slot = 1'b0;
                    if (is_branch) begin
                        if (taken && ins.annul) begin
                            ctl_d.pc = ctl_q.pc + br_off;
                        end else if (taken) begin
                            ctl_d.pend_v  = 1'b1;
                            ctl_d.pend_pc = ctl_q.pc + br_off;
                            ctl_d.in_slot = 1'b1;
                        end
                    end else begin
                        issue_valid = 1'b1;
                        if (ctl_q.exit_pend) begin
                            ctl_d.st        = ST_DONE;
                            ctl_d.exit_pend = 1'b0;
                        end else if (ins.exit_f) begin
                            ctl_d.exit_pend = 1'b1;
                            ctl_d.in_slot   = 1'b1;
                        end
                    end
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_IDLE, pc: '0, pend_v: 1'b0, pend_pc: '0,
                       in_slot: 1'b0, exit_pend: 1'b0, err: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign issue_word = imem_rdata;
    assign issue_opa  = opa;
    assign issue_opb  = opb;
    assign done       = (ctl_q.st == ST_DONE);
    assign error      = ctl_q.err;

    AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && !ctl_q.pend_v && !ctl_q.exit_pend)
        |=> (ctl_q.pc == $past(ctl_q.pc) + 32'd4)) else $error("pc step"); // R1
    AST_SLOT_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_RUN && ctl_q.pend_v && !fault)
        |=> (ctl_q.pc == $past(ctl_q.pend_pc))) else $error("slot redirect"); // R5
    AST_BRANCH_IN_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_RUN && is_branch && ctl_q.in_slot)
        |=> (error && ctl_q.st == ST_IDLE)) else $error("branch in slot"); // R9
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && ctl_q.st == ST_IDLE)) else $error("done pulse"); // R11
    AST_R0_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && ins.src_a == '0) |-> (issue_opa == '0)) else $error("r0 read"); // R3
    AST_NO_BRANCH_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |-> (ins.op <= OP_LAST_FWD)) else $error("issue op"); // R12
endmodule

// File: tb/macro_seq_tb.sv
module macro_seq_tb;
    localparam int PW = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] start_arg = '0;
    logic [3:0]  imem_addr;
    logic [31:0] imem_rdata;
    logic        issue_valid;
    logic [31:0] issue_word, issue_opa, issue_opb;
    logic        wb_en;
    logic [2:0]  wb_idx;
    logic [31:0] wb_data;
    logic        done, error;

    logic [31:0] mem [PW];
    int          n_chk = 0;
    int          n_err = 0;
    int          tr_id [16];
    logic [31:0] tr_a [16];
    logic [31:0] tr_b [16];
    int          tr_n;
    int          saw_done;
    int          saw_err;
    int          done_late;

    always #2 clk = ~clk;

    assign imem_rdata = mem[imem_addr];
    assign wb_en      = issue_valid;
    assign wb_idx     = issue_word[9:7];
    assign wb_data    = {16'h0, issue_word[31:16]};

    macro_seq #(.PROG_WORDS(PW)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .start_arg(start_arg),
        .imem_addr(imem_addr), .imem_rdata(imem_rdata),
        .issue_valid(issue_valid), .issue_word(issue_word),
        .issue_opa(issue_opa), .issue_opb(issue_opb),
        .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data),
        .done(done), .error(error)
    );

    function automatic logic [31:0] mk(input logic [3:0] op, input logic ex, input logic an,
                                       input logic nz, input logic [2:0] dst, input logic [2:0] sa,
                                       input logic [2:0] sb, input logic [15:0] imm);
        return {imm, sb, sa, dst, nz, an, ex, op};
    endfunction

    function automatic logic [31:0] li(input int id, input logic [2:0] dst, input logic ex);
        return mk(4'd1, ex, 1'b0, 1'b0, dst, 3'd0, 3'd0, 16'(id));
    endfunction

    function automatic logic [31:0] br(input logic an, input logic nz, input logic [2:0] sa,
                                       input int off);
        return mk(4'd7, 1'b0, an, nz, 3'd0, sa, 3'd0, 16'(off));
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < PW; i++) mem[i] = 32'h0000_000F;
    endtask

    task automatic run_prog(input logic [31:0] argv);
        tr_n = 0; saw_done = 0; saw_err = 0; done_late = 0;
        @(negedge clk);
        start = 1'b1; start_arg = argv;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < 60; k++) begin
            if (issue_valid && tr_n < 16) begin
                tr_id[tr_n] = int'(issue_word[31:16]);
                tr_a[tr_n]  = issue_opa;
                tr_b[tr_n]  = issue_opb;
                tr_n++;
            end
            if (error) begin saw_err = 1; break; end
            if (done) begin
                saw_done = 1;
                @(negedge clk);
                done_late = int'(done) + int'(issue_valid);
                break;
            end
            @(negedge clk);
        end
    endtask

    task automatic expect_trace(input string req, input int n, input int e0, input int e1,
                                input int e2, input int e3, input int e4);
        int e [5];
        e = '{e0, e1, e2, e3, e4};
        chk(tr_n == n, req, tr_n, n);
        for (int i = 0; i < n && i < tr_n; i++) chk(tr_id[i] == e[i], req, tr_id[i], e[i]);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
        $finish;
    end

    initial begin
        clear_mem();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!done && !error && !issue_valid, "R11 reset", {done, error, issue_valid}, 0);
        chk(imem_addr == 0, "R1 reset pc", imem_addr, 0);

        // R5 R6 R7: sweep annul x condition x register value
        for (int an = 0; an < 2; an++) begin
            for (int nz = 0; nz < 2; nz++) begin
                for (int v = 0; v < 2; v++) begin
                    logic [31:0] argv;
                    bit tk;
                    argv = (v == 0) ? 32'd0 : 32'd5;
                    tk = (nz == 1) ? (argv != 0) : (argv == 0);
                    clear_mem();
                    mem[0] = mk(4'd1, 1'b0, 1'b0, 1'b0, 3'd2, 3'd1, 3'd0, 16'd0);
                    mem[1] = br(an[0], nz[0], 3'd1, 3);
                    mem[2] = li(2, 3'd2, 1'b0);
                    mem[3] = li(3, 3'd2, 1'b1);
                    mem[4] = li(4, 3'd2, 1'b0);
                    mem[5] = li(5, 3'd2, 1'b1);
                    mem[6] = li(6, 3'd2, 1'b0);
                    run_prog(argv);
                    chk(saw_done == 1 && saw_err == 0, "R8 sweep end", saw_done, 1);
                    chk(done_late == 0, "R11 done width", done_late, 0);
                    chk(tr_a[0] == argv, "R2 r1 arg", tr_a[0], argv);
                    chk(tr_b[0] == 0, "R3 r0 operand", tr_b[0], 0);
                    if (!tk)        expect_trace("R7 not taken", 4, 0, 2, 3, 4, 0);
                    else if (an == 0) expect_trace("R5 slot", 5, 0, 2, 4, 5, 6);
                    else            expect_trace("R6 annul", 4, 0, 4, 5, 6, 0);
                end
            end
        end

        // R8: exit in a branch delay slot retires the target
        clear_mem();
        mem[0] = br(1'b0, 1'b0, 3'd0, 5);
        mem[1] = li(1, 3'd2, 1'b1);
        mem[2] = li(2, 3'd2, 1'b0);
        mem[5] = li(5, 3'd2, 1'b0);
        run_prog(32'd1);
        chk(saw_done == 1, "R8 exit in slot", saw_done, 1);
        expect_trace("R8 exit in slot", 2, 1, 5, 0, 0, 0);

        // R4: forward then backward annulled jumps
        clear_mem();
        mem[0] = br(1'b1, 1'b0, 3'd0, 3);
        mem[1] = li(1, 3'd2, 1'b1);
        mem[2] = li(2, 3'd2, 1'b0);
        mem[3] = br(1'b1, 1'b0, 3'd0, -2);
        run_prog(32'd0);
        chk(saw_done == 1, "R4 backward", saw_done, 1);
        expect_trace("R4 backward", 2, 1, 2, 0, 0, 0);

        // R7: branch sees register written just before it
        clear_mem();
        mem[0] = li(9, 3'd4, 1'b0);
        mem[1] = br(1'b1, 1'b1, 3'd4, 2);
        mem[2] = li(2, 3'd2, 1'b1);
        mem[3] = li(3, 3'd2, 1'b1);
        mem[4] = li(4, 3'd2, 1'b0);
        run_prog(32'd0);
        expect_trace("R7 fresh reg", 3, 9, 3, 4, 0, 0);

        // R9: branch in branch slot, branch in exit slot
        clear_mem();
        mem[0] = br(1'b0, 1'b0, 3'd0, 4);
        mem[1] = br(1'b1, 1'b0, 3'd0, 2);
        run_prog(32'd0);
        chk(saw_err == 1 && saw_done == 0, "R9 branch slot", saw_err, 1);
        expect_trace("R9 branch slot", 0, 0, 0, 0, 0, 0);
        clear_mem();
        mem[0] = li(0, 3'd2, 1'b1);
        mem[1] = br(1'b1, 1'b0, 3'd0, 2);
        run_prog(32'd0);
        chk(saw_err == 1, "R9 exit slot", saw_err, 1);
        expect_trace("R9 exit slot", 1, 0, 0, 0, 0, 0);

        // R10: unknown opcodes, jump past end, run off last word
        for (int op = 8; op < 16; op++) begin
            clear_mem();
            mem[0] = li(0, 3'd2, 1'b0);
            mem[1] = mk(4'(op), 1'b0, 1'b0, 1'b0, 3'd2, 3'd0, 3'd0, 16'd1);
            run_prog(32'd0);
            chk(saw_err == 1 && tr_n == 1, "R10 opcode", tr_n, 1);
        end
        @(negedge clk);
        chk(error == 1 && !issue_valid, "R10 error held", error, 1);
        clear_mem();
        mem[0] = br(1'b1, 1'b0, 3'd0, 20);
        run_prog(32'd0);
        chk(saw_err == 1, "R10 past end", saw_err, 1);
        clear_mem();
        mem[0] = br(1'b1, 1'b0, 3'd0, 15);
        mem[15] = li(15, 3'd2, 1'b0);
        run_prog(32'd0);
        chk(saw_err == 1 && tr_n == 1, "R10 fall off", tr_n, 1);

        // R2 R3 R12: register rules through the operand outputs
        clear_mem();
        mem[0] = li(16'h77, 3'd0, 1'b0);
        mem[1] = mk(4'd1, 1'b0, 1'b0, 1'b0, 3'd3, 3'd0, 3'd2, 16'h44);
        mem[2] = mk(4'd2, 1'b1, 1'b0, 1'b0, 3'd5, 3'd3, 3'd2, 16'd2);
        mem[3] = mk(4'd6, 1'b0, 1'b0, 1'b0, 3'd5, 3'd1, 3'd5, 16'd3);
        run_prog(32'hABCD);
        chk(error == 0, "R10 error cleared", error, 0);
        expect_trace("R12 issue", 4, 16'h77, 16'h44, 2, 3, 0);
        chk(tr_a[1] == 0, "R3 r0 write dropped", tr_a[1], 0);
        chk(tr_b[1] == 0, "R2 cleared reg", tr_b[1], 0);
        chk(tr_a[2] == 32'h44, "R12 opa", tr_a[2], 32'h44);
        chk(tr_a[3] == 32'hABCD, "R2 r1 arg", tr_a[3], 32'hABCD);
        chk(tr_b[3] == 2, "R12 opb", tr_b[3], 2);
        chk(!done && !issue_valid, "R11 idle after", done, 0);

        // R1: PC walk of straight-line code
        clear_mem();
        for (int i = 0; i < 6; i++) mem[i] = li(i, 3'd2, i == 5);
        mem[6] = li(6, 3'd2, 1'b0);
        run_prog(32'd0);
        chk(tr_n == 7, "R1 straight line", tr_n, 7);
        for (int i = 0; i < 7 && i < tr_n; i++) chk(tr_id[i] == i, "R1 order", tr_id[i], i);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule